// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a compact 16-bit processor built around a single accumulator. Code and data live in one external single-port memory that returns read data one clock after the address is presented. Each 16-bit instruction word has a 4-bit operation code in its top nibble and a memory operand address in its low bits. Only the low `ADDR_W` bits of that operand are used.

Peripheral transfers use a separate 16-bit I/O bus. The port number is not part of the instruction. It is the contents of the memory word that the operand points to, so an I/O instruction first reads that word and only then pulses the I/O strobe. A clock enable freezes the whole core when it is low. The core is meant to sit beside a small memory and a few registers mapped onto the I/O bus.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low at a rising edge (a synchronous, active-low reset), the program counter and accumulator clear to zero. During reset `mem_addr` reads 0, `wdata` (the accumulator) reads 0 and `mem_we`, `io_rd` and `io_wr` are low. The first fetch after release comes from address 0.
- R2: An instruction word is decoded as opcode = bits 15:12 and operand address = bits `ADDR_W-1:0`. Operand bits 11:`ADDR_W` are ignored. Opcode 0x0 loads the accumulator from memory at the operand address. A load takes 4 cycles from the fetch to the next fetch.
- R3: Opcode 0x1 asserts `mem_we` for exactly one cycle, 2 cycles after its fetch cycle. During that cycle `mem_addr` is the operand address and `wdata` is the accumulator. The instruction takes 3 cycles. At most one of `mem_we`, `io_rd` and `io_wr` is high in any cycle.
- R4: Opcode 0x3 sets the accumulator to the accumulator minus the operand word, modulo 2^16, in 4 cycles.
- R5: Opcode 0x6 sets the accumulator to the accumulator XOR the operand word, in 4 cycles.
- R6: Opcode 0x9 reads the operand word and uses it as `io_addr`. It then raises `io_rd` for one cycle, 4 cycles after its fetch, and loads the accumulator from `io_rdata` sampled in that cycle. The instruction takes 5 cycles.
- R7: Opcode 0xA reads the operand word and uses it as `io_addr`. It then raises `io_wr` for one cycle, 4 cycles after its fetch, with the accumulator on `wdata`. The instruction takes 5 cycles.
- R8: Opcode 0xB continues execution at the operand address. It takes 2 cycles and touches neither memory writes nor I/O.
- R9: Opcode 0xD jumps to the operand address when the accumulator is nonzero. Otherwise it continues with the next word. Both cases take 2 cycles.
- R10: While `ce` is low, no state changes and `mem_we`, `io_rd` and `io_wr` are low. Timing counted in enabled cycles is unchanged.
- R11: Every other opcode (0x2, 0x4, 0x5, 0x7, 0x8, 0xC, 0xE, 0xF) is a 2-cycle no-op. It raises no strobe and leaves the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable; low holds all state |
| mem_addr | output | ADDR_W | Memory address for fetch, operand read or store |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| wdata | output | 16 | Accumulator, used as write data for memory and I/O |
| io_addr | output | 16 | I/O port address, taken from memory |
| io_rd | output | 1 | One-cycle I/O read strobe |
| io_wr | output | 1 | One-cycle I/O write strobe |
| io_rdata | input | 16 | I/O read data, sampled while `io_rd` is high |

## Verification
Each instruction has a fixed length in enabled cycles: 2 for jumps and no-ops, 3 for a store, 4 for memory arithmetic and 5 for I/O. A store strobe is therefore due 2 enabled cycles after its fetch, and an I/O strobe 4 cycles after its fetch. The bench computes the enabled-cycle index of every expected memory write and I/O strobe from these lengths, then compares the index, address and data of each strobe the core actually raises. The same program runs a second time with `ce` pulled low every third clock. The bench counts only enabled cycles, so the expected indices stay the same and every stretched instruction must keep its timing.

// File: rtl/acc_cpu_pkg.sv
// Package acc_cpu_pkg
// Shared opcode values, sequencer states and the opcode classifier for the
// accumulator core. Assumes a 16-bit data word with a 4-bit opcode on top.
package acc_cpu_pkg;

    localparam int WORD_W = 16;
    localparam int OP_W   = 4;

    localparam logic [OP_W-1:0] OP_LOAD  = 4'h0;
    localparam logic [OP_W-1:0] OP_STORE = 4'h1;
    localparam logic [OP_W-1:0] OP_SUB   = 4'h3;
    localparam logic [OP_W-1:0] OP_XOR   = 4'h6;
    localparam logic [OP_W-1:0] OP_IN    = 4'h9;
    localparam logic [OP_W-1:0] OP_OUT   = 4'hA;
    localparam logic [OP_W-1:0] OP_JMP   = 4'hB;
    localparam logic [OP_W-1:0] OP_JNZ   = 4'hD;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_OPER,
        ST_EXEC,
        ST_IO
    } cpu_state_e;

    typedef enum logic [2:0] {
        K_NOP,
        K_JUMP,
        K_STORE,
        K_ALU,
        K_IO
    } op_kind_e;

    // Sort an opcode into the sequence of cycles it needs.
    function automatic op_kind_e op_kind(input logic [OP_W-1:0] op);
        case (op)
            OP_LOAD, OP_SUB, OP_XOR: return K_ALU;
            OP_STORE:                return K_STORE;
            OP_IN, OP_OUT:           return K_IO;
            OP_JMP, OP_JNZ:          return K_JUMP;
            default:                 return K_NOP;
        endcase
    endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
// Module acc_cpu_alu
// Combinational result for the accumulator when an arithmetic opcode
// executes: subtract, exclusive-or, or pass the memory word (load).
// Assumes the caller only uses the result for load, subtract and xor.
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    acc,
    input  logic [W-1:0]    opnd,
    output logic [W-1:0]    result
);

    // Select the operation from the opcode.
    always_comb begin
        case (op)
            OP_SUB:  result = acc - opnd;
            OP_XOR:  result = acc ^ opnd;
            default: result = opnd;
        endcase
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
// Module acc_cpu_ctrl
// Instruction sequencer. It walks each instruction through fetch, decode,
// operand read, execute and I/O, and emits one-cycle load enables and strobes.
// Assumes synchronous memory (data one cycle after the address). Every
// enable and strobe is gated by ce, so a low ce freezes the core.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce,
    input  logic [OP_W-1:0] op_new,
    input  logic [OP_W-1:0] op_held,
    input  logic            acc_nz,
    output cpu_state_e      state,
    output logic            ld_ir,
    output logic            pc_step,
    output logic            pc_jump,
    output logic            acc_from_alu,
    output logic            acc_from_io,
    output logic            ioa_ld,
    output logic            addr_opnd,
    output logic            mem_we,
    output logic            io_rd,
    output logic            io_wr
);

    cpu_state_e nxt;
    op_kind_e   kind_new;
    op_kind_e   kind_held;
    logic       taken;

    assign kind_new  = op_kind(op_new);
    assign kind_held = op_kind(op_held);
    assign taken     = (op_new == OP_JMP) || ((op_new == OP_JNZ) && acc_nz);

    // State register: reset to fetch, advance only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)  state <= ST_FETCH;
        else if (ce) state <= nxt;
    end

    // Next-state choice from the current state and the opcode class.
    always_comb begin
        case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: nxt = (kind_new == K_NOP || kind_new == K_JUMP) ? ST_FETCH : ST_OPER;
            ST_OPER:   nxt = (kind_held == K_STORE) ? ST_FETCH : ST_EXEC;
            ST_EXEC:   nxt = (kind_held == K_IO) ? ST_IO : ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

    // Datapath enables and bus strobes, each valid for one enabled cycle.
    always_comb begin
        ld_ir        = ce && (state == ST_DECODE);
        pc_jump      = ld_ir && (kind_new == K_JUMP) && taken;
        pc_step      = ld_ir && !pc_jump;
        mem_we       = ce && (state == ST_OPER) && (kind_held == K_STORE);
        acc_from_alu = ce && (state == ST_EXEC) && (kind_held == K_ALU);
        ioa_ld       = ce && (state == ST_EXEC) && (kind_held == K_IO);
        io_rd        = ce && (state == ST_IO) && (op_held == OP_IN);
        io_wr        = ce && (state == ST_IO) && (op_held == OP_OUT);
        acc_from_io  = io_rd;
        addr_opnd    = (state == ST_OPER) || (state == ST_EXEC);
    end

    // R6: the read strobe lasts exactly one cycle.
    p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> !io_rd);

    // R7: the write strobe lasts exactly one cycle.
    p_wr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |=> !io_wr);

    // R3: never more than one bus strobe at a time.
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_we, io_rd, io_wr}) <= 1);

    // R10: a disabled cycle leaves the sequencer where it was.
    p_state_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(state));

endmodule

// File: rtl/acc_cpu.sv
// Module acc_cpu
// Top of the accumulator core. It holds the program counter, the instruction
// fields, the accumulator and the I/O address register, and drives the memory
// and I/O buses. Assumes ADDR_W <= 12 and a memory with one cycle of read
// latency that does not read while mem_we is high.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    input  logic [15:0]       mem_rdata,
    output logic [15:0]       wdata,
    output logic [15:0]       io_addr,
    output logic              io_rd,
    output logic              io_wr,
    input  logic [15:0]       io_rdata
);

    localparam int OP_LSB = WORD_W - OP_W;

    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] ir_opnd;
    logic [OP_W-1:0]   ir_op;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] ioa;
    logic [WORD_W-1:0] alu_y;
    cpu_state_e        state;
    logic ld_ir, pc_step, pc_jump, acc_from_alu, acc_from_io, ioa_ld, addr_opnd;

    acc_cpu_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ce           (ce),
        .op_new       (mem_rdata[WORD_W-1:OP_LSB]),
        .op_held      (ir_op),
        .acc_nz       (acc != '0),
        .state        (state),
        .ld_ir        (ld_ir),
        .pc_step      (pc_step),
        .pc_jump      (pc_jump),
        .acc_from_alu (acc_from_alu),
        .acc_from_io  (acc_from_io),
        .ioa_ld       (ioa_ld),
        .addr_opnd    (addr_opnd),
        .mem_we       (mem_we),
        .io_rd        (io_rd),
        .io_wr        (io_wr)
    );

    acc_cpu_alu #(.W(WORD_W)) u_alu (
        .op     (ir_op),
        .acc    (acc),
        .opnd   (mem_rdata),
        .result (alu_y)
    );

    // Architectural registers, each updated only on its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc      <= '0;
            ir_op   <= '0;
            ir_opnd <= '0;
            acc     <= '0;
            ioa     <= '0;
        end else begin
            if (ld_ir) begin
                ir_op   <= mem_rdata[WORD_W-1:OP_LSB];
                ir_opnd <= mem_rdata[ADDR_W-1:0];
            end
            if (pc_jump)      pc <= mem_rdata[ADDR_W-1:0];
            else if (pc_step) pc <= pc + ADDR_W'(1);
            if (acc_from_alu)     acc <= alu_y;
            else if (acc_from_io) acc <= io_rdata;
            if (ioa_ld) ioa <= mem_rdata;
        end
    end

    // Bus outputs: the operand address while an operand is in flight.
    assign mem_addr = addr_opnd ? ir_opnd : pc;
    assign wdata    = acc;
    assign io_addr  = ioa;

    // R1: a reset edge leaves the program counter and accumulator at zero.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0) && (acc == '0));

    // R10: disabled cycles hold the program counter and the accumulator.
    p_regs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(pc) && $stable(acc));

    // R9: a conditional jump on a zero accumulator falls through.
    p_jnz_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && state == ST_DECODE && mem_rdata[WORD_W-1:OP_LSB] == OP_JNZ && acc == '0)
        |=> pc == ADDR_W'($past(pc) + ADDR_W'(1)));

    // R8: an unconditional jump lands on its operand.
    p_jmp_land_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && state == ST_DECODE && mem_rdata[WORD_W-1:OP_LSB] == OP_JMP)
        |=> pc == $past(mem_rdata[ADDR_W-1:0]));

endmodule

// File: tb/test_acc_cpu.sv
// Scoreboard bench: a driver task queues the expected bus events (kind,
// address, data, enabled-cycle index); a negedge monitor pops and compares.
module test_acc_cpu;

    localparam int AW   = 8;
    localparam int K_WR = 0;
    localparam int K_OUT = 1;
    localparam int K_IN = 2;

    typedef struct {
        int          kind;
        logic [15:0] addr;
        logic [15:0] data;
        int          cyc;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [15:0]   mem_rdata;
    logic [15:0]   wdata;
    logic [15:0]   io_addr;
    logic          io_rd;
    logic          io_wr;
    logic [15:0]   io_rdata;

    logic [15:0] mem [0:(1<<AW)-1];
    exp_t        exp_q[$];
    int          total = 0;
    int          bad = 0;
    int          cyc = 0;
    bit          ce_mode = 1'b0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    acc_cpu #(.ADDR_W(AW)) i_acc_cpu (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .wdata(wdata), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_rdata(io_rdata)
    );

    // Synchronous single-port memory: write or read, never both.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= wdata;
        else        mem_rdata <= mem[mem_addr];
    end

    // Peripheral read data derived from the port number.
    assign io_rdata = io_rd ? (io_addr ^ 16'h5A5A) : 16'h0000;

    // Enabled-cycle counter since reset release.
    always @(posedge clk) begin
        if (!rst_n)  cyc <= 0;
        else if (ce) cyc <= cyc + 1;
    end

    task automatic load_prog();
        for (int i = 0; i < (1 << AW); i++) mem[i] = 16'h0000;
        mem[0]  = 16'h0081; mem[1]  = 16'h3082; mem[2]  = 16'h1090;
        mem[3]  = 16'h6083; mem[4]  = 16'hA084; mem[5]  = 16'h9085;
        mem[6]  = 16'h1091; mem[7]  = 16'h2091; mem[8]  = 16'hF091;
        mem[9]  = 16'h1092; mem[10] = 16'h0F81; mem[11] = 16'h1093;
        mem[12] = 16'h3080; mem[13] = 16'hD00C; mem[14] = 16'h1094;
        mem[15] = 16'hB011; mem[16] = 16'h1095; mem[17] = 16'h6082;
        mem[18] = 16'h1096; mem[19] = 16'hB013;
        mem[8'h80] = 16'h0001; mem[8'h81] = 16'h0005; mem[8'h82] = 16'h1234;
        mem[8'h83] = 16'h00FF; mem[8'h84] = 16'hC0DE; mem[8'h85] = 16'h0042;
    endtask

    task automatic push(input int k, input logic [15:0] a, input logic [15:0] d,
                        input int c, input string t);
        exp_t e;
        e.kind = k; e.addr = a; e.data = d; e.cyc = c; e.tag = t;
        exp_q.push_back(e);
    endtask

    // Driver: expected events in enabled cycles from the instruction lengths.
    task automatic push_expect();
        push(K_WR,  16'h0090, 16'hEDD1, 10, "R4 R3");   // 5 - 0x1234
        push(K_OUT, 16'hC0DE, 16'hED2E, 19, "R7 R5");   // xor 0x00FF
        push(K_IN,  16'h0042, 16'h0000, 24, "R6");
        push(K_WR,  16'h0091, 16'h5A18, 27, "R6");      // 0x0042 ^ 0x5A5A
        push(K_WR,  16'h0092, 16'h5A18, 34, "R11");     // no-ops kept acc
        push(K_WR,  16'h0093, 16'h0005, 41, "R2");      // high operand bits ignored
        push(K_WR,  16'h0094, 16'h0000, 74, "R9");      // loop ran five times
        push(K_WR,  16'h0096, 16'h1234, 83, "R8");      // skipped word 16
    endtask

    task automatic check_event(input int k, input logic [15:0] a, input logic [15:0] d);
        exp_t e;
        total++;
        if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R3: unexpected event kind=%0d addr=%h data=%h cyc=%0d, expected none",
                     k, a, d, cyc);
            return;
        end
        e = exp_q.pop_front();
        if (e.kind != k || e.addr != a || e.data != d || e.cyc != cyc) begin
            bad++;
            $display("FAIL %s: got kind=%0d addr=%h data=%h cyc=%0d, expected kind=%0d addr=%h data=%h cyc=%0d",
                     e.tag, k, a, d, cyc, e.kind, e.addr, e.data, e.cyc);
        end
    endtask

    // Monitor: compare strobes away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!ce) begin
                total++;
                if (mem_we || io_rd || io_wr) begin
                    bad++;
                    $display("FAIL R10: strobes %b%b%b while disabled, expected 000",
                             mem_we, io_rd, io_wr);
                end
            end else begin
                if (mem_we) check_event(K_WR, 16'(mem_addr), wdata);
                if (io_wr)  check_event(K_OUT, io_addr, wdata);
                if (io_rd)  check_event(K_IN, io_addr, 16'h0000);
            end
        end
    end

    task automatic check_reset();
        total++;
        if (mem_addr != '0 || wdata != 16'h0 || mem_we || io_rd || io_wr) begin
            bad++;
            $display("FAIL R1: addr=%h acc=%h strobes=%b%b%b, expected 00 0000 000",
                     mem_addr, wdata, mem_we, io_rd, io_wr);
        end
    endtask

    task automatic check_empty();
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R3: %0d expected events missing, expected 0", exp_q.size());
            exp_q.delete();
        end
    endtask

    // Clock-enable driver: low on every third clock in the second run.
    initial begin
        int tick = 0;
        ce = 1'b1;
        forever begin
            @(negedge clk);
            ce = ce_mode ? ((tick % 3) != 1) : 1'b1;
            tick++;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (3000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Main sequence: two runs of the same program, the second with ce gaps.
    initial begin
        rst_n = 1'b0;
        load_prog();
        push_expect();
        repeat (3) @(negedge clk);
        check_reset();                       // R1
        rst_n = 1'b1;
        while (cyc < 100) @(negedge clk);
        check_empty();

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset();                       // R1 after acc held 0x1234
        load_prog();
        push_expect();
        ce_mode = 1'b1;                      // R10 run
        @(negedge clk);
        rst_n = 1'b1;
        while (cyc < 100) @(negedge clk);
        check_empty();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule